// File: doc/BRIEF.md
# Isolation Channel Pulse Decoder

This block sits on the receiving side of a digital isolation channel. The encoder on the far side sends a short set strobe for every rising edge of its input and a reset strobe for every falling edge, and it repeats the current level as periodic refresh strobes while the input is quiet. The decoder rebuilds the logic level from these strobes with a bistable register, so the level is held between strobes.

Two supervisors wrap the bistable. An inactivity watchdog assumes the far side has lost power when no strobe has arrived within a timeout (5 µs by default) and forces the output to its default low level. A local power-good input, passed through a synchronizer, drives a small sequencer: while local power is down the output driver is disabled (high impedance, with data held low), and after power comes up the driver turns on with data at the default low level until the first strobe arrives. A `valid` flag marks that the output is tracking live strobes.

The timeout is given in nanoseconds together with the clock frequency, and the watchdog length in clock cycles is derived from them (1250 cycles at 250 MHz and 5 µs). A refresh interval of about 1 µs means the output can need up to one refresh period after power-up to match the far side.

Top module: `iso_chan_decoder`

## Requirements
- R1: A set strobe alone (set_pulse=1, reset_pulse=0) sampled at a clock edge while the channel is enabled makes data_out 1 after that edge.
- R2: A reset strobe alone (reset_pulse=1, set_pulse=0) sampled at a clock edge while the channel is enabled makes data_out 0 after that edge.
- R3: With no strobes and no timeout, data_out keeps its last value from edge to edge.
- R4: When set_pulse and reset_pulse are both 1 at the same edge, data_out and valid keep their previous values.
- R5: While local power is down (lockout), out_en is 0, data_out is 0, valid is 0, and strobes have no effect on any output.
- R6: power_ok passes through a two-stage synchronizer; out_en becomes 1 after the third rising edge at which power_ok has been sampled 1, with data_out 0 and valid 0 until the first accepted strobe.
- R7: If a strobe is sampled at edge 0 and none at edges 1 through WATCHDOG_CYCLES+1, data_out and valid are 0 after edge WATCHDOG_CYCLES+1 while out_en stays 1.
- R8: Any strobe (set, reset or both) restarts the watchdog; a strobe arriving exactly at edge WATCHDOG_CYCLES+1 prevents the timeout.
- R9: valid becomes 1 at the edge that accepts the first single strobe after power-up or after a timeout, and is cleared by a timeout.
- R10: When power_ok falls, data_out holds its last value until lockout; out_en and data_out drop to 0 after the third edge at which power_ok is sampled 0.
- R11: A synchronous active-high rst makes out_en, data_out and valid 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| power_ok | input | 1 | Local power-good, asynchronous to clk |
| set_pulse | input | 1 | Strobe from the channel: drive output high |
| reset_pulse | input | 1 | Strobe from the channel: drive output low |
| data_out | output | 1 | Rebuilt logic level |
| out_en | output | 1 | Enable for the external tri-state output driver |
| valid | output | 1 | Output is tracking live strobes |

## Verification
Watchdog expiry and strobe arrival can fall on the same clock edge: the counter reaches its limit and the edge that would clear the output also carries a fresh strobe. The bench provokes this by leaving exactly WATCHDOG_CYCLES idle edges after a set strobe and placing the next set strobe on the following edge, then judges that data_out and valid stay 1; one more idle edge in a second run must then drop both. Conflicting set and reset on one edge are also driven against a known level, and the output must not move.

// File: rtl/iso_dec_pkg.sv
package iso_dec_pkg;

  typedef enum logic [1:0] {
    LNK_OFF     = 2'd0,
    LNK_WAIT    = 2'd1,
    LNK_LIVE    = 2'd2,
    LNK_STARVED = 2'd3
  } link_state_t;

  typedef struct packed {
    logic any;
    logic take_hi;
    logic take_lo;
  } strobe_t;

  function automatic strobe_t decode_strobe(input logic s, input logic r);
    strobe_t d;
    d.any     = s | r;
    d.take_hi = s & ~r;
    d.take_lo = r & ~s;
    return d;
  endfunction

endpackage

// File: rtl/iso_dec_sync.sv
module iso_dec_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/iso_dec_watchdog.sv
module iso_dec_watchdog #(
  parameter int LIMIT = 1250
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic activity,
  output logic starve
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

  logic [CW-1:0] idle_q;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      idle_q <= '0;
    end else if (activity) begin
      idle_q <= '0;
    end else if (idle_q != LIM_V) begin
      idle_q <= idle_q + 1'b1;
    end
  end

  assign starve = (idle_q == LIM_V);

endmodule

// File: rtl/iso_dec_bistable.sv
module iso_dec_bistable
  import iso_dec_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    enable,
  input  strobe_t strb,
  input  logic    starve,
  output logic    level
);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      level <= 1'b0;
    end else if (strb.take_hi) begin
      level <= 1'b1;
    end else if (strb.take_lo) begin
      level <= 1'b0;
    end else if (starve && !strb.any) begin
      level <= 1'b0;
    end
  end

endmodule

// File: rtl/iso_dec_seq.sv
module iso_dec_seq
  import iso_dec_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    pwr_good,
  input  strobe_t strb,
  input  logic    starve,
  output logic    rx_enable,
  output logic    drv_en,
  output logic    live
);

  link_state_t state_q, state_d;
  logic        accept;

  assign rx_enable = (state_q != LNK_OFF) && pwr_good;
  assign accept    = rx_enable && (strb.take_hi || strb.take_lo);

  always_comb begin
    state_d = state_q;
    if (!pwr_good) begin
      state_d = LNK_OFF;
    end else begin
      case (state_q)
        LNK_OFF:     state_d = LNK_WAIT;
        LNK_WAIT:    if (accept) state_d = LNK_LIVE;
        LNK_LIVE:    if (starve && !strb.any) state_d = LNK_STARVED;
        LNK_STARVED: if (accept) state_d = LNK_LIVE;
        default:     state_d = LNK_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= LNK_OFF;
    else     state_q <= state_d;
  end

  assign drv_en = (state_q != LNK_OFF);
  assign live   = (state_q == LNK_LIVE);

endmodule

// File: rtl/iso_chan_decoder.sv
module iso_chan_decoder
  import iso_dec_pkg::*;
#(
  parameter int CLK_MHZ         = 250,
  parameter int TIMEOUT_NS      = 5000,
  parameter int WATCHDOG_CYCLES = CLK_MHZ * TIMEOUT_NS / 1000,
  parameter int SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic power_ok,
  input  logic set_pulse,
  input  logic reset_pulse,
  output logic data_out,
  output logic out_en,
  output logic valid
);

  logic    pwr_s;
  logic    rx_en;
  logic    starve;
  strobe_t strb;

  assign strb = decode_strobe(set_pulse, reset_pulse);

  iso_dec_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (power_ok),
    .dout (pwr_s)
  );

  iso_dec_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .pwr_good  (pwr_s),
    .strb      (strb),
    .starve    (starve),
    .rx_enable (rx_en),
    .drv_en    (out_en),
    .live      (valid)
  );

  iso_dec_watchdog #(.LIMIT(WATCHDOG_CYCLES)) u_wdog (
    .clk      (clk),
    .rst      (rst),
    .enable   (rx_en),
    .activity (strb.any),
    .starve   (starve)
  );

  iso_dec_bistable u_latch (
    .clk    (clk),
    .rst    (rst),
    .enable (rx_en),
    .strb   (strb),
    .starve (starve),
    .level  (data_out)
  );

endmodule

// File: rtl/iso_chan_decoder_chk.sv
module iso_chan_decoder_chk #(
  parameter int WD = 1250
) (
  input logic clk,
  input logic rst,
  input logic power_ok,
  input logic set_pulse,
  input logic reset_pulse,
  input logic data_out,
  input logic out_en,
  input logic valid
);

  localparam int IW = $clog2(WD + 2) + 1;
  localparam logic [IW-1:0] TRIP = IW'(WD + 1);

  logic [IW-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (rst || !out_en || set_pulse || reset_pulse) idle_cnt <= '0;
    else if (idle_cnt != TRIP)                      idle_cnt <= idle_cnt + 1'b1;
  end

  AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (rst)
    (out_en && set_pulse && !reset_pulse) |=> (!out_en || data_out)); // R1

  AST_RESET_DRIVES_LOW: assert property (@(posedge clk) disable iff (rst)
    (out_en && reset_pulse && !set_pulse) |=> !data_out); // R2

  AST_CONFLICT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (out_en && set_pulse && reset_pulse) |=> (!out_en || $stable(data_out))); // R4

  AST_LOCKOUT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !out_en |-> (!data_out && !valid)); // R5

  AST_STARVE_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    (idle_cnt == TRIP) |-> (!data_out && !valid)); // R7

  AST_VALID_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    valid |-> out_en); // R9

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (!out_en && !data_out && !valid)); // R11

endmodule

bind iso_chan_decoder iso_chan_decoder_chk #(.WD(WATCHDOG_CYCLES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .power_ok    (power_ok),
  .set_pulse   (set_pulse),
  .reset_pulse (reset_pulse),
  .data_out    (data_out),
  .out_en      (out_en),
  .valid       (valid)
);

// File: tb/tb_iso_chan_decoder.sv
`timescale 1ns/1ps
module tb_iso_chan_decoder;

  localparam int WD = 250 * 5000 / 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic power_ok = 1'b0;
  logic set_pulse = 1'b0;
  logic reset_pulse = 1'b0;
  logic data_out, out_en, valid;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  iso_chan_decoder dut (
    .clk(clk), .rst(rst), .power_ok(power_ok),
    .set_pulse(set_pulse), .reset_pulse(reset_pulse),
    .data_out(data_out), .out_en(out_en), .valid(valid)
  );

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(input logic s, input logic r);
    set_pulse = s; reset_pulse = r;
    @(negedge clk);
    set_pulse = 1'b0; reset_pulse = 1'b0;
  endtask

  task automatic t_reset;
    power_ok = 1'b1;
    rst = 1'b1;
    idle(3);
    chk("R11", "out_en", out_en, 1'b0);
    chk("R11", "data_out", data_out, 1'b0);
    chk("R11", "valid", valid, 1'b0);
    power_ok = 1'b0;
    rst = 1'b0;
    idle(4);
  endtask

  task automatic t_powerup;
    strobe(1'b1, 1'b0);
    chk("R5", "lockout data ignores set", data_out, 1'b0);
    chk("R5", "lockout out_en", out_en, 1'b0);
    power_ok = 1'b1;
    idle(2);
    chk("R6", "out_en after two edges", out_en, 1'b0);
    idle(1);
    chk("R6", "out_en after third edge", out_en, 1'b1);
    chk("R6", "default data low", data_out, 1'b0);
    chk("R9", "valid before first strobe", valid, 1'b0);
    idle(5);
    chk("R6", "data low while waiting", data_out, 1'b0);
  endtask

  task automatic t_set_reset;
    strobe(1'b1, 1'b0);
    chk("R1", "set drives high", data_out, 1'b1);
    chk("R9", "valid on first strobe", valid, 1'b1);
    idle(20);
    chk("R3", "level held", data_out, 1'b1);
    strobe(1'b0, 1'b1);
    chk("R2", "reset drives low", data_out, 1'b0);
    idle(7);
    chk("R3", "low held", data_out, 1'b0);
    strobe(1'b0, 1'b1);
    chk("R2", "repeat reset stays low", data_out, 1'b0);
    strobe(1'b1, 1'b0);
    chk("R1", "set after reset", data_out, 1'b1);
  endtask

  task automatic t_conflict;
    strobe(1'b1, 1'b1);
    chk("R4", "conflict keeps high", data_out, 1'b1);
    chk("R4", "conflict keeps valid", valid, 1'b1);
    strobe(1'b0, 1'b1);
    strobe(1'b1, 1'b1);
    chk("R4", "conflict keeps low", data_out, 1'b0);
  endtask

  task automatic t_watchdog;
    strobe(1'b1, 1'b0);
    idle(WD);
    chk("R7", "no timeout yet", data_out, 1'b1);
    strobe(1'b1, 1'b0);
    chk("R8", "strobe on boundary edge keeps data", data_out, 1'b1);
    chk("R8", "strobe on boundary edge keeps valid", valid, 1'b1);
    idle(WD);
    chk("R7", "still high at limit", data_out, 1'b1);
    idle(1);
    chk("R7", "timeout forces low", data_out, 1'b0);
    chk("R9", "timeout clears valid", valid, 1'b0);
    chk("R7", "driver still enabled", out_en, 1'b1);
    strobe(1'b1, 1'b1);
    chk("R9", "conflict does not revalidate", valid, 1'b0);
    strobe(1'b1, 1'b0);
    chk("R9", "strobe revalidates", valid, 1'b1);
    chk("R1", "strobe restores level", data_out, 1'b1);
  endtask

  task automatic t_conflict_restarts;
    idle(WD - 5);
    strobe(1'b1, 1'b1);
    idle(WD);
    chk("R8", "conflict strobe restarts watchdog", data_out, 1'b1);
    idle(1);
    chk("R7", "timeout after conflict", data_out, 1'b0);
    strobe(1'b1, 1'b0);
  endtask

  task automatic t_powerdown;
    chk("R10", "high before power loss", data_out, 1'b1);
    power_ok = 1'b0;
    idle(2);
    chk("R10", "level held during sync", data_out, 1'b1);
    chk("R10", "driver on during sync", out_en, 1'b1);
    idle(1);
    chk("R10", "lockout drops driver", out_en, 1'b0);
    chk("R10", "lockout drops data", data_out, 1'b0);
    strobe(1'b1, 1'b0);
    chk("R5", "strobe ignored in lockout", data_out, 1'b0);
    chk("R5", "valid low in lockout", valid, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_powerup();
    t_set_reset();
    t_conflict();
    strobe(1'b1, 1'b0);
    t_watchdog();
    t_conflict_restarts();
    t_powerdown();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule